// File: doc/BRIEF.md
# Synchro Drive Protection and Kick Controller

This block supervises the output power stage of a digital-to-synchro drive. Each cycle it looks at synchronous fault flags (reference lost, DC supply lost, case over-temperature, hard output over-current), a digital run/shutdown request and an active-low override. From these it produces a registered power-stage enable and a registered, active-low built-in-test (BIT) flag. The override keeps the stage running through an over-temperature fault only. Every other fault still shuts the stage down.

The block also guards torque-receiver loads against hanging at a false null. It takes a current-limit flag. When that flag stays high for a set number of consecutive cycles and the active-low kick enable is low, the block adds a one-eighth-turn (45°) offset to the commanded binary angle for a fixed number of cycles. A holdoff then follows before another kick can start. Current limiting on its own never drives BIT low. A receiver that stays stuck is reported only once the over-temperature flag rises.

Top module: `synchro_guard`

## Requirements
- R1: `bit_n` is registered. One cycle after any of `ref_lost`, `supply_lost`, `case_hot`, `oc_trip` is 1 or `drive_req` is 0, `bit_n` is 0. One cycle after a cycle with none of these, `bit_n` is 1.
- R2: While `hold_n` is 1, `stage_on` is registered and equals the `bit_n` value of the same cycle.
- R3: While `hold_n` is 0, a `case_hot` fault alone leaves `stage_on` at 1 one cycle later. `bit_n` still goes to 0.
- R4: While `hold_n` is 0, `ref_lost`, `supply_lost`, `oc_trip` or `drive_req`=0 still makes `stage_on` 0 one cycle later.
- R5: While `rst_n` is 0, `bit_n`=0, `stage_on`=0 and `kick_on`=0 after each clock edge. The first clean cycle after release sets `bit_n` and `stage_on` to 1.
- R6: With `kick_dis_n`=0, `kick_on` rises on the edge that samples the PERSIST_CYC-th consecutive cycle of `cur_limit`=1. Any cycle of `cur_limit`=0 restarts the count.
- R7: `kick_on` stays 1 for exactly KICK_CYC cycles. While it is 1, `angle_out` = `angle_cmd` + 2^(ANG_W-3) modulo 2^ANG_W (0x2000 for 16 bits). Otherwise `angle_out` = `angle_cmd`.
- R8: After a kick ends, HOLD_CYC cycles pass before the persistence count restarts. With `cur_limit` held high, the next kick rises HOLD_CYC+PERSIST_CYC cycles after the previous one fell.
- R9: `kick_dis_n`=1 blocks kicks and cancels a running kick, so `kick_on` is 0 one cycle later.
- R10: `cur_limit` on its own never drives `bit_n` or `stage_on` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_lost | input | 1 | Reference lost flag |
| supply_lost | input | 1 | DC supply lost flag |
| case_hot | input | 1 | Case over-temperature flag |
| oc_trip | input | 1 | Hard output over-current flag |
| cur_limit | input | 1 | Output in current limit |
| drive_req | input | 1 | 1 = run the power stage, 0 = digital shutdown |
| hold_n | input | 1 | Active-low over-temperature override |
| kick_dis_n | input | 1 | 0 enables the kick, 1 disables it |
| angle_cmd | input | ANG_W | Commanded binary angle |
| angle_out | output | ANG_W | Angle to the converter, with kick offset |
| kick_on | output | 1 | Kick offset currently applied |
| stage_on | output | 1 | Power-stage enable |
| bit_n | output | 1 | Active-low built-in-test flag |

## Verification
The bench targets four cases:
- Override scope. A design that lets the override mask more than over-temperature keeps the stage on during a supply or reference loss.
- Persistence counter. A counter that does not restart on a single low cycle kicks on interrupted current limiting. An off-by-one counter kicks one cycle early or late.
- Kick length, holdoff and wrap. The second kick's timing exposes a missing holdoff. A command near full scale exposes an offset that saturates instead of wrapping.
- Separation of current limit from BIT. A design that mixes them reports a stuck receiver before it overheats.

// File: rtl/synchro_guard_pkg.sv
// Shared types for the synchro drive protection block.
package synchro_guard_pkg;
    // Kick sequencer phases.
    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_KICK = 2'd1,
        KS_HOLD = 2'd2
    } kick_state_t;
endpackage

// File: rtl/sg_fault_gate.sv
// Fault gate: combines the fault flags into a registered active-low BIT
// flag and a registered power-stage enable.
// Assumes every flag is synchronous to clk.
module sg_fault_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lost,
    input  logic supply_lost,
    input  logic case_hot,
    input  logic oc_trip,
    input  logic drive_req,
    input  logic hold_n,
    output logic stage_on,
    output logic bit_n
);
    logic hard_fault;
    logic any_fault;

    // Faults that the override cannot mask.
    always_comb begin
        hard_fault = ref_lost | supply_lost | oc_trip | ~drive_req;
        any_fault  = hard_fault | case_hot;
    end

    // Register BIT and the stage enable; reset holds the stage off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_n    <= 1'b0;
            stage_on <= 1'b0;
        end else begin
            bit_n    <= ~any_fault;
            stage_on <= hold_n ? ~any_fault : ~hard_fault;
        end
    end

    p_fault_drops_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lost || supply_lost || case_hot || oc_trip || !drive_req) |=> !bit_n);
    p_stage_tracks_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n |=> (stage_on == bit_n));
    p_override_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && case_hot && !ref_lost && !supply_lost && !oc_trip && drive_req)
        |=> (stage_on && !bit_n));
    p_hard_fault_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lost || supply_lost || oc_trip || !drive_req) |=> !stage_on);
endmodule

// File: rtl/sg_kick_timer.sv
// Kick sequencer: waits for sustained current limiting, then raises the
// kick for a fixed time, then holds off before it can re-arm.
// Assumes cur_limit is synchronous to clk.
module sg_kick_timer
    import synchro_guard_pkg::*;
#(
    parameter int PERSIST_CYC = 8,
    parameter int KICK_CYC    = 4,
    parameter int HOLD_CYC    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_limit,
    input  logic kick_dis_n,
    output logic kick_on
);
    localparam int MAX_CYC = (PERSIST_CYC > KICK_CYC)
                           ? ((PERSIST_CYC > HOLD_CYC) ? PERSIST_CYC : HOLD_CYC)
                           : ((KICK_CYC > HOLD_CYC) ? KICK_CYC : HOLD_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PERSIST_LAST = CNT_W'(PERSIST_CYC - 1);
    localparam logic [CNT_W-1:0] KICK_LAST    = CNT_W'(KICK_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_CYC - 1);

    kick_state_t      state;
    logic [CNT_W-1:0] cnt;

    // Step the phase and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || kick_dis_n) begin
            state <= KS_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                KS_IDLE: begin
                    if (!cur_limit) begin
                        cnt <= '0;
                    end else if (cnt == PERSIST_LAST) begin
                        state <= KS_KICK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                KS_KICK: begin
                    if (cnt == KICK_LAST) begin
                        state <= KS_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                KS_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        state <= KS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= KS_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // The kick is applied only in the kick phase.
    always_comb kick_on = (state == KS_KICK);

    p_kick_needs_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kick_on) |-> $past(cur_limit));
    p_gap_after_kick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick_on) |=> !kick_on);
    p_disabled_no_kick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kick_dis_n |=> !kick_on);
endmodule

// File: rtl/sg_angle_offset.sv
// Angle offset: adds one eighth of a turn to the commanded angle while the
// kick is on. Wraps modulo the full angle range.
module sg_angle_offset #(
    parameter int ANG_W = 16
) (
    input  logic [ANG_W-1:0] angle_cmd,
    input  logic             kick_on,
    output logic [ANG_W-1:0] angle_out
);
    localparam logic [ANG_W-1:0] EIGHTH = ANG_W'(1) << (ANG_W - 3);

    // Add the offset; the carry out of the top bit is dropped.
    always_comb angle_out = angle_cmd + (kick_on ? EIGHTH : '0);

    a_no_offset_r7: assert final (kick_on || angle_out == angle_cmd);
endmodule

// File: rtl/synchro_guard.sv
// Synchro drive protection and kick controller top.
// Assumes synchronous fault flags and a synchronous active-low reset.
module synchro_guard #(
    parameter int ANG_W       = 16,
    parameter int PERSIST_CYC = 8,
    parameter int KICK_CYC    = 4,
    parameter int HOLD_CYC    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_lost,
    input  logic             supply_lost,
    input  logic             case_hot,
    input  logic             oc_trip,
    input  logic             cur_limit,
    input  logic             drive_req,
    input  logic             hold_n,
    input  logic             kick_dis_n,
    input  logic [ANG_W-1:0] angle_cmd,
    output logic [ANG_W-1:0] angle_out,
    output logic             kick_on,
    output logic             stage_on,
    output logic             bit_n
);
    sg_fault_gate u_gate (
        .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .supply_lost(supply_lost),
        .case_hot(case_hot), .oc_trip(oc_trip), .drive_req(drive_req),
        .hold_n(hold_n), .stage_on(stage_on), .bit_n(bit_n)
    );

    sg_kick_timer #(
        .PERSIST_CYC(PERSIST_CYC), .KICK_CYC(KICK_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_kick (
        .clk(clk), .rst_n(rst_n), .cur_limit(cur_limit),
        .kick_dis_n(kick_dis_n), .kick_on(kick_on)
    );

    sg_angle_offset #(.ANG_W(ANG_W)) u_offset (
        .angle_cmd(angle_cmd), .kick_on(kick_on), .angle_out(angle_out)
    );

    p_limit_no_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_limit && !ref_lost && !supply_lost && !case_hot && !oc_trip && drive_req)
        |=> (bit_n && stage_on));
endmodule

// File: tb/synchro_guard_bench.sv
module synchro_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_lost, supply_lost, case_hot, oc_trip, cur_limit;
    logic        drive_req, hold_n, kick_dis_n;
    logic [15:0] angle_cmd, angle_out;
    logic        kick_on, stage_on, bit_n;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    synchro_guard u_synchro_guard (
        .clk(clk), .rst_n(rst_n), .ref_lost(ref_lost), .supply_lost(supply_lost),
        .case_hot(case_hot), .oc_trip(oc_trip), .cur_limit(cur_limit),
        .drive_req(drive_req), .hold_n(hold_n), .kick_dis_n(kick_dis_n),
        .angle_cmd(angle_cmd), .angle_out(angle_out), .kick_on(kick_on),
        .stage_on(stage_on), .bit_n(bit_n)
    );

    // {ref, supply, hot, oc, drive_req, hold_n, exp_bit_n, exp_stage_on}
    localparam logic [7:0] VEC [12] = '{
        8'b0000_11_11, 8'b1000_11_00, 8'b0100_11_00, 8'b0010_11_00,
        8'b0001_11_00, 8'b0000_01_00, 8'b0010_10_01, 8'b1010_10_00,
        8'b0100_10_00, 8'b0001_10_00, 8'b0000_00_00, 8'b0000_10_11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // One edge, then return at the falling edge for checking and driving.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ref_lost = 0; supply_lost = 0; case_hot = 0; oc_trip = 0;
        cur_limit = 1'b1; drive_req = 1'b1; hold_n = 1'b1; kick_dis_n = 1'b0;
        angle_cmd = 16'h1234;
        @(negedge clk);
        repeat (12) tick();
        // R5: reset state holds even with current limit present.
        chk("R5 bit_n in reset", bit_n, 0);
        chk("R5 stage_on in reset", stage_on, 0);
        chk("R5 kick_on in reset", kick_on, 0);
        cur_limit = 1'b0; kick_dis_n = 1'b1;
        rst_n = 1'b1;
        tick();
        chk("R5 bit_n first clean", bit_n, 1);
        chk("R5 stage_on first clean", stage_on, 1);

        // R1-R4 table walk, one cycle of latency per vector.
        for (int i = 0; i < 12; i++) begin
            {ref_lost, supply_lost, case_hot, oc_trip, drive_req, hold_n} = VEC[i][7:2];
            tick();
            chk($sformatf("R1 bit_n vec %0d", i), bit_n, VEC[i][1]);
            chk($sformatf("R2/R3/R4 stage_on vec %0d", i), stage_on, VEC[i][0]);
        end
        hold_n = 1'b1;

        // R9: kick disabled, long current limit never kicks.
        cur_limit = 1'b1; kick_dis_n = 1'b1;
        repeat (20) tick();
        chk("R9 no kick when disabled", kick_on, 0);
        // R10: current limit alone leaves BIT and stage untouched.
        chk("R10 bit_n under limit", bit_n, 1);
        chk("R10 stage_on under limit", stage_on, 1);

        // R6: interrupted persistence never kicks.
        kick_dis_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cur_limit = 1'b1;
            repeat (7) tick();
            cur_limit = 1'b0;
            tick();
        end
        chk("R6 interrupted limit no kick", kick_on, 0);

        // R6/R7/R8: sustained limit, wrap near full scale.
        angle_cmd = 16'hF000;
        cur_limit = 1'b1;
        repeat (7) tick();
        chk("R6 no kick after 7 cycles", kick_on, 0);
        chk("R7 angle unmodified", angle_out, 16'hF000);
        tick();
        chk("R6 kick after 8 cycles", kick_on, 1);
        chk("R7 angle wraps with offset", angle_out, 16'h1000);
        chk("R10 bit_n during kick", bit_n, 1);
        repeat (3) tick();
        chk("R7 kick still on at 4th cycle", kick_on, 1);
        tick();
        chk("R7 kick off after 4 cycles", kick_on, 0);
        chk("R7 angle restored", angle_out, 16'hF000);
        repeat (13) tick();
        chk("R8 no kick before holdoff+persist", kick_on, 0);
        tick();
        chk("R8 second kick after holdoff", kick_on, 1);
        angle_cmd = 16'h0100;
        #1 chk("R7 offset on new angle", angle_out, 16'h2100);

        // R9: cancel a running kick.
        kick_dis_n = 1'b1;
        tick();
        chk("R9 kick cancelled", kick_on, 0);

        // Stuck receiver reported only when the case overheats (R1).
        case_hot = 1'b1;
        tick();
        chk("R1 bit_n on hot stuck receiver", bit_n, 0);
        chk("R2 stage_on on hot stuck receiver", stage_on, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule